// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Framing Auto-Detect

This block takes a serial stereo audio stream and turns it into parallel 16-bit left and right samples. The stream has three wires: a bit clock, one data line, and a framing clock. Everything is sampled on the rising edge of the bit clock, and all of the logic runs in that clock domain. When both words of a frame have been captured, they appear on the sample outputs together with a one-cycle valid strobe.

The block handles two framings and chooses between them for every frame, based on how long the framing clock stays high.

- **Right-justified framing (long high pulse).** The framing clock shows which channel is being sent: high means left, low means right. Each word is aligned to the last bit before a framing transition, so any extra leading bits in a phase are dropped.
- **DSP framing (short high pulse).** The pulse acts as a sync. It is followed by a left word and then directly by a right word, both MSB first. A static input selects one of two sync-to-data offsets.

A status output shows which framing the most recent pulse selected.

Top module: `sai_rx_autodetect`

## Requirements
- R1: A synchronous active-high reset clears `left_word`, `right_word`, `word_valid` and `dsp_active` to 0.
- R2: When `frame_clk` stays high for more than 4 bit clocks, the left word is built from the 16 `ser_data` bits sampled on the last 16 rising edges that saw `frame_clk` high. The earliest of these bits becomes bit 15. Bits sampled earlier in the high phase are discarded.
- R3: On the first rising edge that sees `frame_clk` high again after a low phase, if the high phase before that low phase was long, the right word is built from the 16 bits sampled on the last 16 low edges, with the earliest bit as bit 15. Both words appear on the outputs, and `word_valid` pulses, right after that edge.
- R4: In right-justified framing, any high and low phase lengths of at least 16 bit clocks each are accepted.
- R5: The framing decision is made at the edge that first sees `frame_clk` low after a high pulse. A pulse of at most 4 bit clocks sets `dsp_active` to 1. A pulse of 5 or more clears `dsp_active` to 0, and that frame is handled as right-justified.
- R6: With `dsp_fmt_b`=1, DSP capture starts with the bit sampled on the first edge that sees the sync pulse high. That bit and the next 31 bits are taken: the first 16 form the left word and the next 16 form the right word, each MSB first. `word_valid` pulses right after the 32nd bit.
- R7: With `dsp_fmt_b`=0, DSP capture works as in R6 but starts one bit clock later, on the edge after the first edge that sees the sync high.
- R8: In DSP framing, bits that follow the right word are ignored until the next sync. Each frame produces exactly one `word_valid` pulse.
- R9: `word_valid` is never high on two consecutive cycles. `left_word` and `right_word` keep their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_clk | input | 1 | Framing clock: channel select (right-justified) or sync pulse (DSP) |
| ser_data | input | 1 | Serial audio data |
| dsp_fmt_b | input | 1 | Static selection of the DSP offset: 1 = no delay, 0 = one-clock delay |
| left_word | output | 16 | Most recent left sample |
| right_word | output | 16 | Most recent right sample |
| word_valid | output | 1 | One-cycle strobe when a new left/right pair is presented |
| dsp_active | output | 1 | 1 when the most recent framing pulse selected DSP framing |

## Verification
The bench builds the block with its default settings: 16-bit words and a DSP threshold of 4 bit clocks. With these settings, pulse widths of exactly 4 and exactly 5 sit on either side of the decision boundary, so both sides can be driven directly. Right-justified phases run from the 16-clock minimum up to well past it, which exercises the alignment to the final bit. The stream also switches between framings in both directions, and it switches between the two DSP offsets. This covers the cases where a word pending from one framing is released at the sync of the other framing.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

    localparam int SAMPLE_W      = 16;
    localparam int FRAME_W       = 2 * SAMPLE_W;
    localparam int DSP_MAX_PULSE = 4;

    typedef enum logic {
        FMT_DELAYED = 1'b0,
        FMT_DIRECT  = 1'b1
    } dsp_fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    function automatic stereo_t pack_pair(input logic [SAMPLE_W-1:0] l,
                                          input logic [SAMPLE_W-1:0] r);
        stereo_t p;
        p.left  = l;
        p.right = r;
        return p;
    endfunction

endpackage

// File: rtl/sai_rx_edge_tracker.sv
module sai_rx_edge_tracker
    import sai_rx_pkg::*;
#(
    parameter int MAX_SHORT = DSP_MAX_PULSE
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_in,
    output logic rise,
    output logic fall,
    output logic pulse_short,
    output logic dsp_active
);
    localparam int CW = $clog2(MAX_SHORT + 2);
    localparam logic [CW-1:0] SAT_VAL   = CW'(MAX_SHORT + 1);
    localparam logic [CW-1:0] SHORT_LIM = CW'(MAX_SHORT);

    logic          frame_q;
    logic [CW-1:0] hi_cnt;

    assign rise        = frame_in & ~frame_q;
    assign fall        = ~frame_in & frame_q;
    assign pulse_short = (hi_cnt <= SHORT_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q    <= 1'b0;
            hi_cnt     <= '0;
            dsp_active <= 1'b0;
        end else begin
            frame_q <= frame_in;
            if (rise) begin
                hi_cnt <= CW'(1);
            end else if (frame_in && hi_cnt != SAT_VAL) begin
                hi_cnt <= hi_cnt + CW'(1);
            end
            if (fall) begin
                dsp_active <= pulse_short;
            end
        end
    end

    AST_PULSE_COUNT_SAT: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= SAT_VAL); // R5

    AST_MODE_TRACKS_PULSE: assert property (@(posedge clk) disable iff (rst)
        fall |=> (dsp_active == ($past(hi_cnt) <= SHORT_LIM))); // R5

endmodule

// File: rtl/sai_rx_rj_capture.sv
module sai_rx_rj_capture
    import sai_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sdata,
    input  logic    rise,
    input  logic    fall,
    input  logic    pulse_short,
    input  logic    dsp_active,
    output logic    emit,
    output stereo_t pair
);
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_seen;

    assign emit = rise & left_seen & ~dsp_active;
    assign pair = pack_pair(left_hold, shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            left_hold <= '0;
            left_seen <= 1'b0;
        end else begin
            shreg <= {shreg[SAMPLE_W-2:0], sdata};
            if (fall) begin
                if (!pulse_short) begin
                    left_hold <= shreg;
                end
                left_seen <= ~pulse_short;
            end else if (rise) begin
                left_seen <= 1'b0;
            end
        end
    end

    AST_RJ_PENDING_LEFT_LONG: assert property (@(posedge clk) disable iff (rst)
        left_seen |-> !dsp_active); // R3

endmodule

// File: rtl/sai_rx_dsp_capture.sv
module sai_rx_dsp_capture
    import sai_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sdata,
    input  logic     rise,
    input  logic     fall,
    input  logic     pulse_short,
    input  dsp_fmt_e fmt,
    output logic     emit,
    output stereo_t  pair
);
    localparam int CW = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] shreg_nxt;
    logic [CW-1:0]      cnt;
    logic               armed;
    logic               sync_ok;
    logic               last_bit;

    assign shreg_nxt = {shreg[FRAME_W-2:0], sdata};
    assign last_bit  = armed & ~rise & (cnt == LAST_IDX);
    assign emit      = last_bit & sync_ok;
    assign pair      = stereo_t'(shreg_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            cnt     <= '0;
            armed   <= 1'b0;
            sync_ok <= 1'b0;
        end else begin
            if (fall && pulse_short) begin
                sync_ok <= 1'b1;
            end
            if (rise) begin
                armed   <= 1'b1;
                sync_ok <= 1'b0;
                if (fmt == FMT_DIRECT) begin
                    shreg <= shreg_nxt;
                    cnt   <= CW'(1);
                end else begin
                    cnt   <= '0;
                end
            end else if (armed) begin
                shreg <= shreg_nxt;
                cnt   <= cnt + CW'(1);
                if (last_bit) begin
                    armed <= 1'b0;
                end
            end
        end
    end

    AST_DSP_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cnt < CW'(FRAME_W))); // R8

    AST_DSP_DISARM_AFTER_WORDS: assert property (@(posedge clk) disable iff (rst)
        emit |=> !armed); // R8

endmodule

// File: rtl/sai_rx_autodetect.sv
module sai_rx_autodetect
    import sai_rx_pkg::*;
#(
    parameter int MAX_SHORT = DSP_MAX_PULSE
) (
    input  logic                bit_clk,
    input  logic                rst,
    input  logic                frame_clk,
    input  logic                ser_data,
    input  logic                dsp_fmt_b,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                word_valid,
    output logic                dsp_active
);
    logic     rise, fall, pulse_short;
    logic     rj_emit, dsp_emit;
    stereo_t  rj_pair, dsp_pair, sel_pair;
    dsp_fmt_e fmt;

    assign fmt = dsp_fmt_b ? FMT_DIRECT : FMT_DELAYED;

    sai_rx_edge_tracker #(.MAX_SHORT(MAX_SHORT)) u_edges (
        .clk         (bit_clk),
        .rst         (rst),
        .frame_in    (frame_clk),
        .rise        (rise),
        .fall        (fall),
        .pulse_short (pulse_short),
        .dsp_active  (dsp_active)
    );

    sai_rx_rj_capture u_rj (
        .clk         (bit_clk),
        .rst         (rst),
        .sdata       (ser_data),
        .rise        (rise),
        .fall        (fall),
        .pulse_short (pulse_short),
        .dsp_active  (dsp_active),
        .emit        (rj_emit),
        .pair        (rj_pair)
    );

    sai_rx_dsp_capture u_dsp (
        .clk         (bit_clk),
        .rst         (rst),
        .sdata       (ser_data),
        .rise        (rise),
        .fall        (fall),
        .pulse_short (pulse_short),
        .fmt         (fmt),
        .emit        (dsp_emit),
        .pair        (dsp_pair)
    );

    assign sel_pair = dsp_emit ? dsp_pair : rj_pair;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            left_word  <= '0;
            right_word <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= rj_emit | dsp_emit;
            if (rj_emit || dsp_emit) begin
                left_word  <= sel_pair.left;
                right_word <= sel_pair.right;
            end
        end
    end

    AST_SINGLE_SOURCE: assert property (@(posedge bit_clk) disable iff (rst)
        !(rj_emit && dsp_emit)); // R8

    AST_VALID_ONE_CYCLE: assert property (@(posedge bit_clk) disable iff (rst)
        word_valid |=> !word_valid); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge bit_clk) disable iff (rst)
        !word_valid |-> ($stable(left_word) && $stable(right_word))); // R9

endmodule

// File: tb/sai_rx_autodetect_test.sv
module sai_rx_autodetect_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, frame_clk, ser_data, fmt_b;
    logic [15:0] lw, rw;
    logic        vld, dsp;

    sai_rx_autodetect uut (
        .bit_clk    (clk),
        .rst        (rst),
        .frame_clk  (frame_clk),
        .ser_data   (ser_data),
        .dsp_fmt_b  (fmt_b),
        .left_word  (lw),
        .right_word (rw),
        .word_valid (vld),
        .dsp_active (dsp)
    );

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] hist = '0;
    logic        prev_vld = 1'b0;
    logic [31:0] prev_out = '0;
    logic [31:0] mon_e;
    string       mon_t;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic rbit();
        return 1'($urandom);
    endfunction

    task automatic slot(input logic f, input logic d);
        @(negedge clk);
        frame_clk = f;
        ser_data  = d;
        hist      = {hist[30:0], d};
    endtask

    // R2 R3 R4: right-justified frame, pair released at the next rising framing edge
    task automatic rj_frame(input logic [15:0] l, input logic [15:0] r,
                            input int hi, input int lo);
        for (int i = 0; i < hi; i++) slot(1'b1, (i >= hi - 16) ? l[hi-1-i] : rbit());
        for (int i = 0; i < lo; i++) slot(1'b0, (i >= lo - 16) ? r[lo-1-i] : rbit());
        exp_q.push_back({l, r});
        tag_q.push_back("R2,R3,R4");
        @(posedge clk); #1;
        check(dsp == 1'b0, "R5", "mode after long pulse", 32'(dsp), 32'd0);
    endtask

    // R5 R6 R7 R8: sync pulse of width pw, frame of total slots
    task automatic dsp_frame(input logic [15:0] l, input logic [15:0] r,
                             input int pw, input int total);
        int          off;
        logic [31:0] w;
        logic [15:0] lcap;
        off  = fmt_b ? 0 : 1;
        w    = {l, r};
        lcap = '0;
        if (pw <= 4 && total >= off + 32) begin
            exp_q.push_back(w);
            tag_q.push_back(fmt_b ? "R6" : "R7");
        end
        for (int s = 0; s < total; s++) begin
            slot(s < pw, (s >= off && s < off + 32) ? w[31-(s-off)] : rbit());
            if (s == pw - 1) lcap = hist[15:0];
        end
        if (pw > 4) begin
            exp_q.push_back({lcap, hist[15:0]});
            tag_q.push_back("R5");
        end
        @(posedge clk); #1;
        check(dsp == (pw <= 4), "R5", "mode after pulse", 32'(dsp), 32'(pw <= 4));
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (vld) begin
                check(!prev_vld, "R9", "valid width", 32'(prev_vld), 32'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected valid", {lw, rw}, 32'd0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    check({lw, rw} == mon_e, mon_t, "sample pair", {lw, rw}, mon_e);
                end
            end else begin
                check({lw, rw} == prev_out, "R9", "hold", {lw, rw}, prev_out);
            end
            prev_vld = vld;
            prev_out = {lw, rw};
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; frame_clk = 1'b0; ser_data = 1'b0; fmt_b = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(lw == 16'h0, "R1", "left after reset", 32'(lw), 32'd0);
        check(rw == 16'h0, "R1", "right after reset", 32'(rw), 32'd0);
        check(vld == 1'b0, "R1", "valid after reset", 32'(vld), 32'd0);
        check(dsp == 1'b0, "R1", "mode after reset", 32'(dsp), 32'd0);
        repeat (3) slot(1'b0, 1'b0);

        // R4 minimum phases, padded phases, long high phase
        rj_frame(16'hA55A, 16'h0FF0, 16, 16);
        rj_frame(16'h8001, 16'h7FFE, 24, 20);
        rj_frame(16'hFFFF, 16'h0000, 40, 17);
        for (int k = 0; k < 12; k++)
            rj_frame(16'($urandom), 16'($urandom), 16 + int'($urandom % 20), 16 + int'($urandom % 20));

        // R6 direct offset, widths 1..4, random trailing bits (R8)
        fmt_b = 1'b1;
        for (int k = 0; k < 10; k++)
            dsp_frame(16'($urandom), 16'($urandom), 1 + int'($urandom % 4), 34 + int'($urandom % 20));
        dsp_frame(16'h1234, 16'hFEDC, 4, 40);
        dsp_frame(16'h8000, 16'h0001, 1, 32);

        // R7 delayed offset
        fmt_b = 1'b0;
        for (int k = 0; k < 10; k++)
            dsp_frame(16'($urandom), 16'($urandom), 1 + int'($urandom % 4), 34 + int'($urandom % 20));
        dsp_frame(16'hC3C3, 16'h3C3C, 1, 33);

        // R5 boundary: width 5 is not a sync, width 4 is
        dsp_frame(16'h0F0F, 16'hF0F0, 5, 40);
        dsp_frame(16'h5555, 16'hAAAA, 4, 40);

        // framing changes both ways
        rj_frame(16'h1357, 16'h2468, 18, 22);
        dsp_frame(16'h9ABC, 16'hDEF0, 2, 45);
        fmt_b = 1'b1;
        dsp_frame(16'h4321, 16'h8765, 3, 36);
        rj_frame(16'h7777, 16'h1111, 16, 16);

        // final rising edge releases the last right-justified pair
        repeat (20) slot(1'b1, rbit());
        repeat (6) slot(1'b0, rbit());
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8", "pairs still pending", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule